// File: doc/BRIEF.md
# Multi-Format Serial Audio Deserializer

This block takes a stereo audio stream carried on three wires (a bit clock, a word-select line and a serial data line) and turns it into parallel left and right samples, each 24 bits wide. All three wires are brought into the block's own clock domain through one synchronizer of equal depth, so their timing relative to each other is kept. The block detects rising edges of the bit clock in that domain. The serial lines therefore have to toggle well below the system clock rate; the bench uses one bit clock per eight system clocks.

A two-bit format input selects one of four framings at run time:

| Code | Framing | Word position | Left channel when word select is |
|------|---------|---------------|----------------------------------|
| 00 | I2S | MSB one bit after the edge | low |
| 01 | left-justified | MSB at the edge | high |
| 10 | right-justified, 24 bits | LSB just before the edge | high |
| 11 | right-justified, 16 bits | LSB just before the edge | high |

A word is complete when the word-select line changes. A left word followed by a right word is released as one pair, together with a one-cycle strobe. A right word that follows no left word is discarded.

Top module: `sad_rx`

## Requirements
- R1: Serial data is taken on rising edges of the bit clock, most significant bit first, and is treated as two's complement.
- R2: With format 00 (I2S), a low word select marks the left channel. The MSB is the second bit of a word-select phase, and 24 bits are captured. Each phase must hold at least 25 bit clocks.
- R3: With format 01 (left-justified), a high word select marks the left channel. The MSB is the first bit of the phase, and 24 bits are captured.
- R4: With format 10 (right-justified, 24 bits), a high word select marks the left channel. The sample is the last 24 bits before the word-select edge, so its LSB is the bit just before that edge. Each phase must hold at least 48 bit clocks.
- R5: With format 11 (right-justified, 16 bits), a high word select marks the left channel. The sample is the last 16 bits before the edge, placed in output bits 23:8 with bits 7:0 set to zero. Each phase must hold at least 32 bit clocks.
- R6: Bits outside the selected word have no effect on the output. These are bit clocks after the 24th captured bit in formats 00 and 01, and bits ahead of the word in formats 10 and 11.
- R7: When a left word is followed by a right word, both appear on the outputs together and `pair_valid` is high for exactly one clock. This happens after the word-select edge that ends the right phase.
- R8: A right word that is not preceded by a held left word is dropped, and no strobe is produced for it.
- R9: The phase in progress when reset is released is never emitted. Output begins only with words whose phase started at a word-select edge.
- R10: While `rst_n` is low, both sample outputs are zero and `pair_valid` stays low, whatever the serial lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| bclk | input | 1 | Serial bit clock, sampled in the clk domain |
| wsel | input | 1 | Word-select (channel) line |
| sdata | input | 1 | Serial data line |
| fmt_sel | input | 2 | Framing code (00 I2S, 01 left-justified, 10 right-justified 24, 11 right-justified 16) |
| left_smp | output | 24 | Left sample of the latest pair |
| right_smp | output | 24 | Right sample of the latest pair |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench builds the block with its default parameters: a two-stage input synchronizer and a two-stage reset synchronizer. It drives one bit clock for every eight system clocks, which keeps every bit-clock edge visible after synchronization.

It sweeps all four format codes, each at two phase lengths, including the shortest phase each framing allows. The sweeps send extreme sample values and fill the unused bits with ones, so that any leakage of bits outside the word shows up in the outputs.

Separate runs cover three cases: a right word that has no left partner, traffic on the serial lines while reset is held, and the discarded phase that straddles the release of reset.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SHORT_W  = 16;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ16 = 2'b11
  } fmt_e;

  typedef logic [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/sad_sync.sv
module sad_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sad_framer.sv
module sad_framer
  import sad_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    ws,
  input  logic    sd,
  input  fmt_e    fmt,
  output logic    word_done,
  output logic    word_left,
  output sample_t word_data
);
  localparam int CNT_W = $clog2(SAMPLE_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ws_prev_q, ws_prev_n;
  logic             started_q, started_n;
  logic             framed_q,  framed_n;
  logic [CNT_W-1:0] cnt_q,     cnt_n;
  sample_t          acc_q,     acc_n;
  sample_t          sr_q,      sr_n;
  logic             done_q,    done_n;
  logic             left_q,    left_n;
  sample_t          data_q,    data_n;
  sample_t          picked;
  logic             boundary;
  int               pos;

  assign boundary = tick && started_q && (ws != ws_prev_q);

  always_comb begin
    unique case (fmt)
      FMT_RJ24: picked = sr_q;
      FMT_RJ16: picked = {sr_q[SHORT_W-1:0], {(SAMPLE_W-SHORT_W){1'b0}}};
      default:  picked = acc_q;
    endcase
  end

  always_comb begin
    ws_prev_n = ws_prev_q;
    started_n = started_q;
    framed_n  = framed_q;
    cnt_n     = cnt_q;
    acc_n     = acc_q;
    sr_n      = sr_q;
    done_n    = 1'b0;
    left_n    = left_q;
    data_n    = data_q;
    pos       = 0;
    if (tick) begin
      ws_prev_n = ws;
      started_n = 1'b1;
      sr_n      = {sr_q[SAMPLE_W-2:0], sd};
      if (boundary) begin
        if (framed_q) begin
          done_n = 1'b1;
          data_n = picked;
          left_n = (fmt == FMT_I2S) ? ~ws_prev_q : ws_prev_q;
        end
        framed_n = 1'b1;
        cnt_n    = CNT_W'(1);
        acc_n    = (fmt == FMT_LJ) ? {sd, {(SAMPLE_W-1){1'b0}}} : '0;
      end else begin
        if (fmt == FMT_LJ && int'(cnt_q) < SAMPLE_W) begin
          pos        = SAMPLE_W - 1 - int'(cnt_q);
          acc_n[pos] = sd;
        end else if (fmt == FMT_I2S && cnt_q != '0 && int'(cnt_q) <= SAMPLE_W) begin
          pos        = SAMPLE_W - int'(cnt_q);
          acc_n[pos] = sd;
        end
        if (cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= 1'b0;
      started_q <= 1'b0;
      framed_q  <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      sr_q      <= '0;
      done_q    <= 1'b0;
      left_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      ws_prev_q <= ws_prev_n;
      started_q <= started_n;
      framed_q  <= framed_n;
      cnt_q     <= cnt_n;
      acc_q     <= acc_n;
      sr_q      <= sr_n;
      done_q    <= done_n;
      left_q    <= left_n;
      data_q    <= data_n;
    end
  end

  assign word_done = done_q;
  assign word_left = left_q;
  assign word_data = data_q;
endmodule

// File: rtl/sad_pairer.sv
module sad_pairer
  import sad_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    word_done,
  input  logic    word_left,
  input  sample_t word_data,
  output sample_t left_out,
  output sample_t right_out,
  output logic    pair_strobe
);
  logic    have_left_q, have_left_n;
  sample_t hold_q,      hold_n;
  sample_t lout_q,      lout_n;
  sample_t rout_q,      rout_n;
  logic    strobe_q,    strobe_n;

  always_comb begin
    have_left_n = have_left_q;
    hold_n      = hold_q;
    lout_n      = lout_q;
    rout_n      = rout_q;
    strobe_n    = 1'b0;
    if (word_done) begin
      if (word_left) begin
        have_left_n = 1'b1;
        hold_n      = word_data;
      end else begin
        have_left_n = 1'b0;
        if (have_left_q) begin
          lout_n   = hold_q;
          rout_n   = word_data;
          strobe_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left_q <= 1'b0;
      hold_q      <= '0;
      lout_q      <= '0;
      rout_q      <= '0;
      strobe_q    <= 1'b0;
    end else begin
      have_left_q <= have_left_n;
      hold_q      <= hold_n;
      lout_q      <= lout_n;
      rout_q      <= rout_n;
      strobe_q    <= strobe_n;
    end
  end

  assign left_out    = lout_q;
  assign right_out   = rout_q;
  assign pair_strobe = strobe_q;
endmodule

// File: rtl/sad_rx.sv
module sad_rx
  import sad_pkg::*;
#(
  parameter int IN_STAGES  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                wsel,
  input  logic                sdata,
  input  logic [1:0]          fmt_sel,
  output logic [SAMPLE_W-1:0] left_smp,
  output logic [SAMPLE_W-1:0] right_smp,
  output logic                pair_valid
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic [2:0]            lines_sync;
  logic                  bclk_prev_q;
  logic                  tick;
  logic                  word_done;
  logic                  word_left;
  sample_t               word_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  sad_sync #(.STAGES(IN_STAGES), .WIDTH(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   ({bclk, wsel, sdata}),
    .dout  (lines_sync)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) bclk_prev_q <= 1'b0;
    else            bclk_prev_q <= lines_sync[2];
  end
  assign tick = lines_sync[2] & ~bclk_prev_q;

  sad_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .ws        (lines_sync[1]),
    .sd        (lines_sync[0]),
    .fmt       (fmt_e'(fmt_sel)),
    .word_done (word_done),
    .word_left (word_left),
    .word_data (word_data)
  );

  sad_pairer u_pairer (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .word_done   (word_done),
    .word_left   (word_left),
    .word_data   (word_data),
    .left_out    (left_smp),
    .right_out   (right_smp),
    .pair_strobe (pair_valid)
  );
endmodule

// File: rtl/sad_rx_chk.sv
module sad_rx_chk
  import sad_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fmt_sel,
  input logic                pair_valid,
  input logic [SAMPLE_W-1:0] left_smp,
  input logic [SAMPLE_W-1:0] right_smp,
  input logic                word_done,
  input logic                word_left,
  input sample_t             word_data
);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  // R8
  pair_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> $past(word_done && !word_left));

  // R7
  pair_carries_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> right_smp == $past(word_data));

  // R5
  short_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && $past(fmt_sel) == 2'b11) |-> word_data[SAMPLE_W-SHORT_W-1:0] == '0);

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!pair_valid && left_smp == '0 && right_smp == '0);
    end
  end
endmodule

bind sad_rx sad_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt_sel    (fmt_sel),
  .pair_valid (pair_valid),
  .left_smp   (left_smp),
  .right_smp  (right_smp),
  .word_done  (word_done),
  .word_left  (word_left),
  .word_data  (word_data)
);

// File: tb/sad_rx_tb.sv
module sad_rx_tb;
  logic        clk;
  logic        rst_n;
  logic        bclk;
  logic        wsel;
  logic        sdata;
  logic [1:0]  fmt_sel;
  logic [23:0] left_smp;
  logic [23:0] right_smp;
  logic        pair_valid;

  int checks;
  int errors;
  int got_n;
  bit done;
  logic [23:0] got_l [16];
  logic [23:0] got_r [16];

  sad_rx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .wsel       (wsel),
    .sdata      (sdata),
    .fmt_sel    (fmt_sel),
    .left_smp   (left_smp),
    .right_smp  (right_smp),
    .pair_valid (pair_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (pair_valid && got_n < 16) begin
      got_l[got_n] = left_smp;
      got_r[got_n] = right_smp;
      got_n++;
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    bclk = 1'b0; wsel = w; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic phase_bit(input int f, input int k, input int n, input logic [23:0] d);
    case (f)
      0: return (k >= 1 && k <= 24) ? d[24-k] : 1'b1;
      1: return (k < 24) ? d[23-k] : 1'b1;
      2: return (k >= n-24) ? d[n-1-k] : 1'b1;
      default: return (k >= n-16) ? d[n-1-k] : 1'b1;
    endcase
  endfunction

  function automatic logic [23:0] expect_word(input int f, input logic [23:0] d);
    return (f == 3) ? {d[15:0], 8'h00} : d;
  endfunction

  task automatic send_phase(input int f, input logic w, input int n, input logic [23:0] d);
    for (int k = 0; k < n; k++) send_bit(w, phase_bit(f, k, n, d));
  endtask

  task automatic do_reset(input int f);
    rst_n = 1'b0; bclk = 1'b0; wsel = 1'b0; sdata = 1'b0;
    fmt_sel = 2'(f);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    got_n = 0;
  endtask

  function automatic logic [23:0] sample_val(input int i, input int f);
    case (i)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'hFFFFFF;
      3: return 24'h000001;
      default: return 24'(i * 24'h1F3A5 + f * 24'h5A5A3);
    endcase
  endfunction

  initial begin
    checks = 0; errors = 0; got_n = 0; done = 0;
    rst_n = 1'b0; bclk = 1'b0; wsel = 1'b0; sdata = 1'b0; fmt_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R10: outputs during reset, with the serial lines active
    check("R10 left in reset", left_smp, 24'h0);
    check("R10 right in reset", right_smp, 24'h0);
    fmt_sel = 2'b01;
    for (int p = 0; p < 4; p++) send_phase(1, p[0], 24, 24'hABCDEF);
    check("R10 strobes in reset", 24'(got_n), 24'd0);

    // R1 R2 R3 R4 R5 R6 R7 R9: sweep formats and phase lengths
    for (int f = 0; f < 4; f++) begin
      for (int li = 0; li < 2; li++) begin
        int n;
        logic lft;
        n = (f == 0) ? (li == 0 ? 25 : 32) :
            (f == 1) ? (li == 0 ? 24 : 32) :
            (f == 2) ? (li == 0 ? 48 : 64) : (li == 0 ? 32 : 48);
        lft = (f == 0) ? 1'b0 : 1'b1;
        do_reset(f);
        // R9: lead-in phase on the right level is never reported
        send_phase(f, ~lft, n, 24'h5A5A5A);
        for (int i = 0; i < 4; i++) begin
          send_phase(f, lft,  n, sample_val(2*i, f));
          send_phase(f, ~lft, n, sample_val(2*i+1, f));
        end
        send_phase(f, lft, n, 24'h0);
        repeat (20) @(negedge clk);
        check($sformatf("R7 R9 pair count fmt %0d len %0d", f, n), 24'(got_n), 24'd4);
        for (int i = 0; i < 4; i++) begin
          check($sformatf("R1 R2 R3 R4 R5 R6 left fmt %0d len %0d #%0d", f, n, i),
                got_l[i], expect_word(f, sample_val(2*i, f)));
          check($sformatf("R1 R2 R3 R4 R5 R6 right fmt %0d len %0d #%0d", f, n, i),
                got_r[i], expect_word(f, sample_val(2*i+1, f)));
        end
      end
    end

    // R8: an unpaired right word is dropped
    do_reset(1);
    send_phase(1, 1'b1, 32, 24'h111111);
    send_phase(1, 1'b0, 32, 24'h222222);
    send_phase(1, 1'b1, 32, 24'h333333);
    send_phase(1, 1'b0, 32, 24'h444444);
    send_phase(1, 1'b1, 32, 24'h000000);
    repeat (20) @(negedge clk);
    check("R8 pair count", 24'(got_n), 24'd1);
    check("R8 left", got_l[0], 24'h333333);
    check("R8 right", got_r[0], 24'h444444);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule